// File: doc/BRIEF.md
# Reset Source Status Logger

This block keeps a 32-bit status word that tells software why the last reset happened. It watches a vector of cold-reset request lines, a vector of warm-reset request lines and a vector of timeout event pulses. From the edges of those lines it decides which requester caused a reset and which timeouts fired while a hardware-sequenced warm reset was in progress.

A cold reset ends when the last active cold request drops. At that point the word is replaced. It then holds only the cold sources that released in that final cycle, and everything else is zeroed. A warm reset works differently: it only ever adds bits, one for each warm source that releases its request. Timeout pulses also only add bits, and only while some warm request is held. Software reads the word over a small register bus with combinational read data. It clears bits by writing ones to them.

Field placement: cold sources in bits [3:0], warm sources in [11:8], timeouts in [19:16]. All other bits are always zero.

Top module: `rst_src_log`

## Requirements
- R1: After the synchronous reset `rst`, the status word reads 0x0000_0000.
- R2: When the cold request vector goes from nonzero to all-zero, the status word becomes, after that clock edge, exactly the set of cold sources whose request fell in that cycle. Source i maps to bit i. All warm, timeout and other bits become 0.
- R3: A cold source that released its request in an earlier cycle, while other cold requests were still held, is not logged when the last request falls.
- R4: When warm request i falls from 1 to 0, bit 8+i is set after that edge. No other bit is changed by the warm event.
- R5: A timeout pulse on line j in a cycle where at least one warm request is 1 sets bit 16+j. A pulse in a cycle with no warm request asserted has no effect.
- R6: A write (`wr_en`=1, `addr`=0) clears each status bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R7: A hardware set in the same cycle as a clearing write leaves that bit at 1. A cold commit in the same cycle as a write or a warm/timeout event produces exactly the R2 value.
- R8: Bits outside [3:0], [11:8] and [19:16] always read 0. Writes to any address other than 0 change nothing.
- R9: `rdata` shows the status word in the same cycle that `addr` is 0. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cold_req | input | 4 | Cold-reset request lines, one per source |
| warm_req | input | 4 | Warm-reset request lines, one per source |
| tmo_pulse | input | 4 | Timeout event pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data; ones clear status bits |
| rdata | output | 32 | Read data, combinational from addr |

## Verification
The cold logger is tested with four kinds of cold request pattern:
- staggered releases, which separate the last releaser from earlier ones;
- a simultaneous release of several sources, which must log all of them;
- a single pulse;
- a cold commit that coincides with a write and with warm activity, which shows whether the commit fully replaces the word.

Warm releases and timeouts are driven with warm requests both held and absent, which shows whether the timeout bits are gated. Clearing writes are mixed with zero bits, unused bits, wrong addresses and same-cycle hardware sets. A long seeded random run interleaves all of these and compares every cycle against a bench model.

// File: rtl/rst_src_log_pkg.sv
package rst_src_log_pkg;
  localparam int unsigned STAT_W    = 32;
  localparam int unsigned COLD_LSB  = 0;
  localparam int unsigned WARM_LSB  = 8;
  localparam int unsigned TMO_LSB   = 16;
  localparam int unsigned FIELD_MAX = 8;

  typedef logic [STAT_W-1:0] stat_t;

  function automatic stat_t field_mask(input int unsigned lsb, input int unsigned n);
    stat_t m;
    m = '0;
    for (int unsigned i = 0; i < n; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rst_edge_trk.sv
module rst_edge_trk #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req,
  output logic [W-1:0] fall,
  output logic         all_released,
  output logic         active_q
);
  logic [W-1:0] req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      active_q <= 1'b0;
    end else begin
      req_q    <= req;
      active_q <= |req;
    end
  end

  // Candidates: lines that were high last cycle and are low now.
  assign fall         = req_q & ~req;
  assign all_released = active_q && (req == '0);
endmodule

// File: rtl/rst_stat_reg.sv
module rst_stat_reg
  import rst_src_log_pkg::*;
#(
  parameter int unsigned N_COLD = 4,
  parameter int unsigned N_WARM = 4,
  parameter int unsigned N_TMO  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cold_commit,
  input  logic [N_COLD-1:0] cold_set,
  input  logic [N_WARM-1:0] warm_set,
  input  logic [N_TMO-1:0]  tmo_set,
  input  stat_t             clr_mask,
  output stat_t             stat_q
);
  localparam stat_t COLD_M = field_mask(COLD_LSB, N_COLD);
  localparam stat_t WARM_M = field_mask(WARM_LSB, N_WARM);
  localparam stat_t TMO_M  = field_mask(TMO_LSB, N_TMO);
  localparam stat_t LIVE_M = COLD_M | WARM_M | TMO_M;

  stat_t cold_img, hw_set, stat_d;

  always_comb begin
    cold_img = '0;
    hw_set   = '0;
    for (int unsigned i = 0; i < N_COLD; i++) cold_img[COLD_LSB+i] = cold_set[i];
    for (int unsigned i = 0; i < N_WARM; i++) hw_set[WARM_LSB+i]   = warm_set[i];
    for (int unsigned i = 0; i < N_TMO; i++)  hw_set[TMO_LSB+i]    = tmo_set[i];
    if (cold_commit) stat_d = cold_img;
    else             stat_d = ((stat_q & ~clr_mask) | hw_set) & LIVE_M;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end
endmodule

// File: rtl/rst_rd_mux.sv
module rst_rd_mux
  import rst_src_log_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  stat_t             stat_q,
  output stat_t             rdata
);
  assign rdata = (addr == '0) ? stat_q : '0;
endmodule

// File: rtl/rst_src_log.sv
module rst_src_log
  import rst_src_log_pkg::*;
#(
  parameter int unsigned N_COLD = 4,
  parameter int unsigned N_WARM = 4,
  parameter int unsigned N_TMO  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_COLD-1:0] cold_req,
  input  logic [N_WARM-1:0] warm_req,
  input  logic [N_TMO-1:0]  tmo_pulse,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  logic [N_COLD-1:0] cold_fall;
  logic [N_WARM-1:0] warm_fall;
  logic              cold_done, cold_act, warm_done, warm_act;
  logic [N_TMO-1:0]  tmo_gated;
  stat_t             clr_mask, stat_q;

  rst_edge_trk #(.W(N_COLD)) u_cold (
    .clk(clk), .rst(rst), .req(cold_req),
    .fall(cold_fall), .all_released(cold_done), .active_q(cold_act)
  );

  rst_edge_trk #(.W(N_WARM)) u_warm (
    .clk(clk), .rst(rst), .req(warm_req),
    .fall(warm_fall), .all_released(warm_done), .active_q(warm_act)
  );

  assign tmo_gated = tmo_pulse & {N_TMO{|warm_req}};
  assign clr_mask  = (wr_en && addr == '0) ? wdata : '0;

  rst_stat_reg #(.N_COLD(N_COLD), .N_WARM(N_WARM), .N_TMO(N_TMO)) u_stat (
    .clk(clk), .rst(rst), .cold_commit(cold_done), .cold_set(cold_fall),
    .warm_set(warm_fall), .tmo_set(tmo_gated), .clr_mask(clr_mask),
    .stat_q(stat_q)
  );

  rst_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
    .addr(addr), .stat_q(stat_q), .rdata(rdata)
  );
endmodule

// File: rtl/rst_src_log_chk.sv
module rst_src_log_chk
  import rst_src_log_pkg::*;
#(
  parameter int unsigned N_COLD = 4,
  parameter int unsigned N_WARM = 4,
  parameter int unsigned N_TMO  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [N_COLD-1:0] cold_req,
  input logic [N_WARM-1:0] warm_req,
  input logic [N_TMO-1:0]  tmo_pulse,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [31:0]       stat_q
);
  localparam stat_t LIVE_M = field_mask(COLD_LSB, N_COLD) |
                             field_mask(WARM_LSB, N_WARM) | field_mask(TMO_LSB, N_TMO);

  logic [N_COLD-1:0] c_d;
  logic [N_WARM-1:0] w_d;
  logic              ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_d <= '0; w_d <= '0; ok <= 1'b0;
    end else begin
      c_d <= cold_req; w_d <= warm_req; ok <= 1'b1;
    end
  end

  stat_t cold_exp;
  always_comb begin
    cold_exp = '0;
    for (int unsigned i = 0; i < N_COLD; i++) cold_exp[COLD_LSB+i] = c_d[i];
  end

  logic quiet;
  assign quiet = (c_d == '0 || cold_req != '0) && ((w_d & ~warm_req) == '0) &&
                 (tmo_pulse == '0 || warm_req == '0);

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> stat_q == '0);
  a_r2_cold_commit: assert property (@(posedge clk) disable iff (rst)
    (ok && c_d != '0 && cold_req == '0) |=> stat_q == $past(cold_exp));
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~LIVE_M) == '0);
  a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
    (ok && wr_en && addr == '0 && quiet) |=> stat_q == $past(stat_q & ~wdata));
  a_r8_other_addr: assert property (@(posedge clk) disable iff (rst)
    (ok && !(wr_en && addr == '0) && quiet) |=> $stable(stat_q));
  always_comb begin
    if (addr != '0) a_r9_rd_zero: assert (rdata == '0);
  end
endmodule

bind rst_src_log rst_src_log_chk #(
  .N_COLD(N_COLD), .N_WARM(N_WARM), .N_TMO(N_TMO), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst), .cold_req(cold_req), .warm_req(warm_req),
  .tmo_pulse(tmo_pulse), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .stat_q(stat_q)
);

// File: tb/test_rst_src_log.sv
`timescale 1ns/1ps
module test_rst_src_log;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  cold_req, warm_req, tmo_pulse;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_st;
  logic [3:0]  pc, pw;

  always #5 clk = ~clk;

  rst_src_log i_rst_src_log (
    .clk(clk), .rst(rst), .cold_req(cold_req), .warm_req(warm_req),
    .tmo_pulse(tmo_pulse), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata)
  );

  function automatic logic [31:0] model(input logic [31:0] st, input logic [3:0] pcv,
      input logic [3:0] ccv, input logic [3:0] pwv, input logic [3:0] cwv,
      input logic [3:0] t, input logic we, input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] n;
    if (pcv != 4'h0 && ccv == 4'h0) return {28'h0, pcv};
    n = st;
    if (we && a == 8'h00) n = n & ~wd;
    n = n | {20'h0, (pwv & ~cwv), 8'h00};
    if (cwv != 4'h0) n = n | {12'h0, t, 16'h0000};
    return n & 32'h000F_0F0F;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Drive one cycle (inputs set after negedge), step model at posedge, check at next negedge.
  task automatic tick(input string tag, input logic [3:0] c, input logic [3:0] w,
      input logic [3:0] t, input logic we, input logic [7:0] a, input logic [31:0] wd);
    cold_req = c; warm_req = w; tmo_pulse = t; wr_en = we; addr = a; wdata = wd;
    #1;
    check({tag, " comb read"}, rdata, (a == 8'h00) ? exp_st : 32'h0);
    @(posedge clk);
    exp_st = model(exp_st, pc, c, pw, w, t, we, a, wd);
    pc = c; pw = w;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h00;
    #1;
    check(tag, rdata, exp_st);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] rc, rw;
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    rst = 1'b1; cold_req = 0; warm_req = 0; tmo_pulse = 0; wr_en = 0; addr = 0; wdata = 0;
    exp_st = 0; pc = 0; pw = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    check("R1 reset value", rdata, 32'h0);

    // R4 warm releases add bits; R5 timeouts gated by warm activity
    tick("R5 tmo no warm ignored", 0, 0, 4'hF, 0, 0, 0);
    tick("R4 warm hold",           0, 4'h5, 0, 0, 0, 0);
    tick("R5 tmo during warm",     0, 4'h5, 4'h2, 0, 0, 0);
    tick("R4 warm release one",    0, 4'h4, 0, 0, 0, 0);
    tick("R4 warm release rest",   0, 0, 0, 0, 0, 0);
    check("R4 value", exp_st, 32'h0002_0500);
    // R6 w1c; R8 unused and other address
    tick("R8 other addr write",    0, 0, 0, 1, 8'h04, 32'hFFFF_FFFF);
    tick("R6 write zeros",         0, 0, 0, 1, 0, 32'h0);
    tick("R6 clear bit8",          0, 0, 0, 1, 0, 32'h0000_0100);
    tick("R8 unused write ones",   0, 0, 0, 1, 0, 32'hFFF0_F0F0);
    // R7 hw set beats clear
    tick("R7 warm hold",           0, 4'h2, 0, 0, 0, 0);
    tick("R7 set vs clear",        0, 0, 0, 1, 0, 32'hFFFF_FFFF);
    check("R7 bit9 kept", exp_st, 32'h0000_0200);
    // R9 nonzero address read
    tick("R9 read addr 8",         0, 0, 0, 0, 8'h08, 0);
    // R2/R3 staggered overlap
    tick("R3 cold a",              4'h7, 0, 0, 0, 0, 0);
    tick("R3 release 0",           4'h6, 0, 0, 0, 0, 0);
    tick("R3 release 1",           4'h4, 4'h1, 0, 0, 0, 0);
    tick("R3 last release",        0, 4'h1, 0, 0, 0, 0);
    check("R3 only last", exp_st, 32'h0000_0004);
    // R2 simultaneous release, R7 commit with write and warm event
    tick("R2 cold b",              4'hB, 4'h1, 0, 0, 0, 0);
    tick("R7 commit with write",   0, 0, 4'h1, 1, 0, 32'h0000_000F);
    check("R2 simultaneous", exp_st, 32'h0000_000B);
    tick("R2 pulse",               4'h8, 0, 0, 0, 0, 0);
    tick("R2 pulse end",           0, 0, 0, 0, 0, 0);

    for (int k = 0; k < 3000; k++) begin
      rc = pc; rw = pw;
      if ($urandom_range(0, 9) == 0) rc = rc ^ 4'($urandom_range(1, 15));
      if ($urandom_range(0, 3) == 0) rw = rw ^ 4'($urandom_range(1, 15));
      tick("R2 R4 R5 R6 random", rc, rw, 4'($urandom_range(0, 15)) & {4{$urandom_range(0, 3) == 0}},
           $urandom_range(0, 4) == 0, ($urandom_range(0, 5) == 0) ? 8'h10 : 8'h00, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule